// File: doc/BRIEF.md
# Quad-Data-Rate Burst SRAM Core

This block is an on-chip static memory with two independent data ports: a write port with its own input bus and a read port with its own output bus, so reads and writes never contend for a shared data bus. A single command address bus serves both ports. The block runs on one beat clock at twice the command rate. An internal phase flag, which is also brought out, splits every command cycle into two halves. In phase 0 the read select and the address are sampled as a read command. In phase 1 the write select and the address are sampled as a write command.

Each address names a group of four data words, and every access moves all four as a burst of four beats, one per beat clock. Write beats carry active-low byte-lane enables. Write data is collected in a pending buffer and committed to the array in one step with its last beat. A read that targets the pending address is served from the buffer for the lanes already captured, so a read always returns the most recent data. The read latency can be selected: 1.5 command cycles (three beats) or 1 command cycle (two beats).

Control is three small state machines. The write sequencer has the states W_IDLE, W_FILL0, W_FILL1, W_FILL2 and W_LAST. An accepted write moves it from W_IDLE to W_FILL0. It then steps through W_FILL1 and W_FILL2 to W_LAST. From W_LAST, which commits the burst, it goes back to W_FILL0 if a new write is accepted and to W_IDLE otherwise. The read gate has the states R_READY, R_GAP1, R_GAP2 and R_GAP3. An accepted read moves it from R_READY to R_GAP1, and it then steps unconditionally through the gap states back to R_READY. The output sequencer has the states O_IDLE, O_B1, O_B2 and O_B3. A launched read moves it from O_IDLE to O_B1. It then steps through O_B2 to O_B3, which returns to O_B1 on a new launch and to O_IDLE otherwise.

Top module: `qdr_burst_sram`

## Requirements
- R1: The read and write ports run concurrently: a read burst may be returned on rd_data while a write burst is being taken in on wr_data, and each port behaves as if the other were idle.
- R2: The `phase` output is 0 on the first beat after reset and toggles on every beat. Read commands (rd_sel_n low) are sampled only at phase-0 edges and write commands (wr_sel_n low) only at phase-1 edges. A select that is low at the other phase is ignored.
- R3: Each address holds four words, at word offsets 0 to 3. Beats 0, 1, 2 and 3 of every burst map to offsets 0, 1, 2 and 3 in that strict order, for reads and writes alike, and this holds up to the highest address.
- R4: A write accepted at edge t takes its data words for offsets 0 to 3 from wr_data at edges t+1, t+2, t+3 and t+4.
- R5: On each write beat, wr_be_n[i] low writes lane i, which is bits [9i+8:9i]. wr_be_n[i] high leaves that lane's stored contents unchanged.
- R6: A read beat registered at edge E returns data that includes every write beat captured before E, even when that burst has not yet been committed to the array. This forwarding works per lane.
- R7: With lat_short=0, beat 0 of a read accepted at edge r appears on the outputs after edge r+3, which is 1.5 command cycles. With lat_short=1 it appears after edge r+2. The remaining beats follow on consecutive edges.
- R8: rd_valid is high for exactly the four beats of each read burst. When rd_valid is low, rd_data is all zeros.
- R9: An accepted burst runs to completion on both ports whatever the selects do afterwards. wr_data that arrives outside a write burst is never stored.
- R10: Each port accepts at most one command per four beats. A select asserted at the command edge two beats after an accepted command on that port is ignored, and the command edge four beats after it is accepted.
- R11: The synchronous active-high reset clears the phase flag, drops a partly received write without committing it, cancels reads in flight, and forces rd_valid and rd_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst | input | 1 | Synchronous active-high reset |
| lat_short | input | 1 | 1 selects two-beat read latency, 0 selects three-beat latency |
| cmd_addr | input | AW | Shared address: read address in phase 0, write address in phase 1 |
| rd_sel_n | input | 1 | Active-low read command select |
| wr_sel_n | input | 1 | Active-low write command select |
| wr_data | input | LANES*LW | Write beat data |
| wr_be_n | input | LANES | Active-low per-lane write enables |
| phase | output | 1 | Command phase flag |
| rd_data | output | LANES*LW | Read beat data, zero when not valid |
| rd_valid | output | 1 | Read beat valid |

## Verification
The bench builds the block with AW=4, LANES=4 and LW=9. This gives 16 addresses of four 36-bit words, so the top address 15 and both latency settings are reached in a short run. The four 9-bit lanes let alternating lane masks show a per-lane merge between forwarded and stored data. Commands are placed back to back, too early, in the wrong phase, and overlapping on the same address, so that forwarding, ignored selects and a reset in the middle of a write all show up at the read port.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int BEATS = 4;

    typedef enum logic [2:0] {
        W_IDLE, W_FILL0, W_FILL1, W_FILL2, W_LAST
    } wr_state_t;

    typedef enum logic [1:0] {
        R_READY, R_GAP1, R_GAP2, R_GAP3
    } rd_gate_t;

    typedef enum logic [1:0] {
        O_IDLE, O_B1, O_B2, O_B3
    } out_state_t;
endpackage

// File: rtl/qdr_bank.sv
module qdr_bank #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [LANES-1:0]    wlane,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);
    localparam int W     = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we && wlane[l])
                store[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/qdr_wr_ctrl.sv
module qdr_wr_ctrl import qdr_pkg::*; #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            phase,
    input  logic                            sel_n,
    input  logic [AW-1:0]                   addr,
    input  logic [LANES*LW-1:0]             wdata,
    input  logic [LANES-1:0]                be_n,
    output logic                            fwd_act,
    output logic [AW-1:0]                   fwd_addr,
    output logic [BEATS-1:0][LANES*LW-1:0]  fwd_data,
    output logic [BEATS-1:0][LANES-1:0]     fwd_lane,
    output logic                            commit,
    output logic [AW-1:0]                   commit_addr,
    output logic [BEATS-1:0][LANES*LW-1:0]  commit_data,
    output logic [BEATS-1:0][LANES-1:0]     commit_lane
);
    localparam int W = LANES * LW;

    wr_state_t                     state, nstate;
    logic                          accept;
    logic [1:0]                    cap_idx;
    logic [AW-1:0]                 pw_addr;
    logic [BEATS-1:0][W-1:0]       pw_data;
    logic [BEATS-1:0][LANES-1:0]   pw_lane;

    assign accept = phase && !sel_n && (state == W_IDLE || state == W_LAST);

    always_comb begin
        nstate  = state;
        cap_idx = 2'd0;
        unique case (state)
            W_IDLE:  nstate = accept ? W_FILL0 : W_IDLE;
            W_FILL0: begin nstate = W_FILL1; cap_idx = 2'd0; end
            W_FILL1: begin nstate = W_FILL2; cap_idx = 2'd1; end
            W_FILL2: begin nstate = W_LAST;  cap_idx = 2'd2; end
            W_LAST:  begin nstate = accept ? W_FILL0 : W_IDLE; cap_idx = 2'd3; end
            default: nstate = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= W_IDLE;
            pw_addr <= '0;
            pw_lane <= '0;
        end else begin
            state <= nstate;
            if (state == W_LAST)
                pw_lane <= '0;
            else if (state != W_IDLE) begin
                pw_data[cap_idx] <= wdata;
                pw_lane[cap_idx] <= ~be_n;
            end
            if (accept)
                pw_addr <= addr;
        end
    end

    always_comb begin
        commit      = (state == W_LAST);
        commit_addr = pw_addr;
        for (int b = 0; b < BEATS; b++) begin
            commit_data[b] = (b == BEATS-1) ? wdata : pw_data[b];
            commit_lane[b] = (b == BEATS-1) ? ~be_n : pw_lane[b];
        end
        fwd_act  = (state != W_IDLE);
        fwd_addr = pw_addr;
        fwd_data = pw_data;
        fwd_lane = pw_lane;
    end

    // R9: a started burst cannot drop back to idle before its last beat
    p_no_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (state == W_FILL0 || state == W_FILL1 || state == W_FILL2) |=> (state != W_IDLE));
    // R4: a commit follows three captured beats
    p_commit_seq_r4: assert property (@(posedge clk) disable iff (rst)
        commit |-> ($past(state) == W_FILL2 || $past(state) == W_LAST) && $past(state, 2) != W_IDLE);
endmodule

// File: rtl/qdr_rd_ctrl.sv
module qdr_rd_ctrl import qdr_pkg::*; #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                phase,
    input  logic                sel_n,
    input  logic                lat_short,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] look_data,
    output logic [AW-1:0]       look_addr,
    output logic [1:0]          look_beat,
    output logic [LANES*LW-1:0] rd_data,
    output logic                rd_valid
);
    localparam int W     = LANES * LW;
    localparam int DELAY = 3;

    rd_gate_t                gate, ngate;
    out_state_t              ost, nost;
    logic                    accept, launch, launch_ok, look_en;
    logic [DELAY-1:0]        pv;
    logic [DELAY-1:0][AW-1:0] pa;
    logic [AW-1:0]           laddr, oaddr;

    assign accept = !phase && !sel_n && (gate == R_READY);

    always_comb begin
        ngate = gate;
        unique case (gate)
            R_READY: ngate = accept ? R_GAP1 : R_READY;
            R_GAP1:  ngate = R_GAP2;
            R_GAP2:  ngate = R_GAP3;
            R_GAP3:  ngate = R_READY;
            default: ngate = R_READY;
        endcase
    end

    assign launch    = lat_short ? pv[1] : pv[2];
    assign laddr     = lat_short ? pa[1] : pa[2];
    assign launch_ok = launch && (ost == O_IDLE || ost == O_B3);

    always_comb begin
        nost      = ost;
        look_beat = 2'd0;
        unique case (ost)
            O_IDLE:  nost = launch_ok ? O_B1 : O_IDLE;
            O_B1:    begin nost = O_B2; look_beat = 2'd1; end
            O_B2:    begin nost = O_B3; look_beat = 2'd2; end
            O_B3:    begin nost = launch_ok ? O_B1 : O_IDLE; look_beat = launch_ok ? 2'd0 : 2'd3; end
            default: nost = O_IDLE;
        endcase
        look_en   = launch_ok || (ost != O_IDLE);
        look_addr = launch_ok ? laddr : oaddr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate     <= R_READY;
            ost      <= O_IDLE;
            pv       <= '0;
            pa       <= '0;
            oaddr    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            gate     <= ngate;
            ost      <= nost;
            pv       <= {pv[DELAY-2:0], accept};
            pa       <= {pa[DELAY-2:0], addr};
            if (launch_ok)
                oaddr <= laddr;
            rd_valid <= look_en;
            rd_data  <= look_en ? look_data : {W{1'b0}};
        end
    end

    // R10: no second read is taken at the next command edge
    p_gap_r10: assert property (@(posedge clk) disable iff (rst)
        accept |-> ##2 !accept);
    // R7: a burst on the read bus only starts from a launched read
    p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> $past(launch));
    // R8: the last output beat is preceded by the third
    p_burst_four_r8: assert property (@(posedge clk) disable iff (rst)
        (ost == O_B3) |-> $past(ost) == O_B2);
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram import qdr_pkg::*; #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lat_short,
    input  logic [AW-1:0]       cmd_addr,
    input  logic                rd_sel_n,
    input  logic                wr_sel_n,
    input  logic [LANES*LW-1:0] wr_data,
    input  logic [LANES-1:0]    wr_be_n,
    output logic                phase,
    output logic [LANES*LW-1:0] rd_data,
    output logic                rd_valid
);
    localparam int W = LANES * LW;

    logic                        ph;
    logic                        fwd_act, commit;
    logic [AW-1:0]               fwd_addr, commit_addr, look_addr;
    logic [BEATS-1:0][W-1:0]     fwd_data, commit_data, bank_q;
    logic [BEATS-1:0][LANES-1:0] fwd_lane, commit_lane;
    logic [1:0]                  look_beat;
    logic [W-1:0]                merged, sel_word, fw_word;
    logic [LANES-1:0]            fw_ln;
    logic                        hit;

    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end
    assign phase = ph;

    qdr_wr_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) u_wr (
        .clk(clk), .rst(rst), .phase(ph), .sel_n(wr_sel_n), .addr(cmd_addr),
        .wdata(wr_data), .be_n(wr_be_n),
        .fwd_act(fwd_act), .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_lane(fwd_lane),
        .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data),
        .commit_lane(commit_lane)
    );

    qdr_rd_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) u_rd (
        .clk(clk), .rst(rst), .phase(ph), .sel_n(rd_sel_n), .lat_short(lat_short),
        .addr(cmd_addr), .look_data(merged), .look_addr(look_addr),
        .look_beat(look_beat), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    for (genvar k = 0; k < BEATS; k++) begin : g_bank
        qdr_bank #(.AW(AW), .LANES(LANES), .LW(LW)) u_bank (
            .clk(clk), .we(commit), .waddr(commit_addr), .wdata(commit_data[k]),
            .wlane(commit_lane[k]), .raddr(look_addr), .rdata(bank_q[k])
        );
    end

    assign sel_word = bank_q[look_beat];
    assign fw_word  = fwd_data[look_beat];
    assign fw_ln    = fwd_lane[look_beat];
    assign hit      = fwd_act && (fwd_addr == look_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign merged[l*LW +: LW] = (hit && fw_ln[l]) ? fw_word[l*LW +: LW]
                                                      : sel_word[l*LW +: LW];
    end

    // R8: the read bus is quiet outside a burst
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0);
    // R2: the phase flag alternates every beat
    p_phase_alt_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase != $past(phase));
endmodule

// File: tb/tb_qdr_burst_sram.sv
`timescale 1ns/1ps
module tb_qdr_burst_sram;
    localparam int AW = 4, LANES = 4, LW = 9, W = LANES * LW;
    localparam int NV = 16;
    // {rd, raddr, wr, waddr, seed, mask, req}
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 4'd0,  1'b1, 4'd3,  8'h11, 4'b0000, 4'd4},   // R4 plain write
        {1'b0, 4'd0,  1'b1, 4'd6,  8'h99, 4'b0000, 4'd10},  // R10 too early, ignored
        {1'b1, 4'd3,  1'b1, 4'd5,  8'h22, 4'b0000, 4'd1},   // R1 read and write together
        {1'b1, 4'd5,  1'b0, 4'd0,  8'h00, 4'b0000, 4'd10},  // R10 read ignored
        {1'b1, 4'd5,  1'b1, 4'd7,  8'h33, 4'b0000, 4'd3},   // R3 order
        {1'b0, 4'd0,  1'b0, 4'd0,  8'h00, 4'b0000, 4'd9},   // R9 selects high
        {1'b0, 4'd0,  1'b1, 4'd7,  8'h44, 4'b0000, 4'd6},   // R6 overwrite 7
        {1'b1, 4'd7,  1'b0, 4'd0,  8'h00, 4'b0000, 4'd6},   // R6 forwarded read
        {1'b0, 4'd0,  1'b1, 4'd3,  8'h55, 4'b1010, 4'd5},   // R5 masked write
        {1'b1, 4'd3,  1'b0, 4'd0,  8'h00, 4'b0000, 4'd5},   // R5 masked forward
        {1'b0, 4'd0,  1'b1, 4'd15, 8'h66, 4'b0000, 4'd3},   // R3 top address
        {1'b0, 4'd0,  1'b0, 4'd0,  8'h00, 4'b0000, 4'd8},   // R8 idle
        {1'b1, 4'd15, 1'b0, 4'd0,  8'h00, 4'b0000, 4'd3},   // R3 read top
        {1'b1, 4'd6,  1'b0, 4'd0,  8'h00, 4'b0000, 4'd10},  // R10 ignored
        {1'b1, 4'd5,  1'b1, 4'd5,  8'h77, 4'b0101, 4'd6},   // R6 same cycle
        {1'b0, 4'd0,  1'b0, 4'd0,  8'h00, 4'b0000, 4'd7}    // R7 drain
    };

    logic clk = 1'b0, rst = 1'b1, lat_short = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [W-1:0] wr_data = '0;
    logic [LANES-1:0] wr_be_n = '0;
    logic phase, rd_valid;
    logic [W-1:0] rd_data;

    qdr_burst_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut (
        .clk(clk), .rst(rst), .lat_short(lat_short), .cmd_addr(cmd_addr),
        .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wr_data(wr_data),
        .wr_be_n(wr_be_n), .phase(phase), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    string cur_req = "R11";
    logic [W-1:0] mem [(1<<AW)*4];
    logic [W-1:0] pbuf [4];
    logic [LANES-1:0] plane [4];
    int wrem = 0, rblk = 0, ecnt = 0;
    logic mph = 1'b0;
    logic [AW-1:0] waddr_m = '0;
    logic [7:0] wseed = '0, nseed = '0;
    logic [3:0] wmask = '0, nmask = '0;
    logic sv [64];
    logic [AW-1:0] sa [64];
    int sk [64];

    function automatic logic [W-1:0] gen(input logic [7:0] s, input int b);
        logic [W-1:0] r;
        for (int l = 0; l < LANES; l++)
            r[l*LW +: LW] = {s ^ 8'(l*37) ^ 8'(b*11), 1'(b)};
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int s;
        logic ev;
        logic [W-1:0] ed, w;
        s = ecnt % 64;
        if (rst) begin
            mph = 1'b0; wrem = 0; rblk = 0;
            for (int i = 0; i < 64; i++) sv[i] = 1'b0;
            for (int b = 0; b < 4; b++) plane[b] = '0;
            check(!rd_valid && rd_data == '0 && !phase, "R11", "reset state",
                  {rd_valid, rd_data}, {1'b0, {W{1'b0}}});
            ecnt++;
            return;
        end
        ev = 1'b0; ed = '0;
        if (sv[s]) begin
            ev = 1'b1;
            ed = mem[int'(sa[s])*4 + sk[s]];
            if (wrem > 0 && waddr_m == sa[s])
                for (int l = 0; l < LANES; l++)
                    if (plane[sk[s]][l]) ed[l*LW +: LW] = pbuf[sk[s]][l*LW +: LW];
            sv[s] = 1'b0;
        end
        check(rd_valid === ev && rd_data === ed, cur_req, "read port {valid,data}",
              {rd_valid, rd_data}, {ev, ed});
        if (wrem > 0) begin
            int b;
            b = 4 - wrem;
            pbuf[b] = gen(wseed, b);
            plane[b] = ~wmask;
            if (b == 3) begin
                for (int k = 0; k < 4; k++) begin
                    w = mem[int'(waddr_m)*4 + k];
                    for (int l = 0; l < LANES; l++)
                        if (plane[k][l]) w[l*LW +: LW] = pbuf[k][l*LW +: LW];
                    mem[int'(waddr_m)*4 + k] = w;
                    plane[k] = '0;
                end
            end
            wrem--;
        end
        if (mph && !wr_sel_n && wrem == 0) begin
            waddr_m = cmd_addr; wrem = 4; wseed = nseed; wmask = nmask;
        end
        if (!mph && !rd_sel_n && rblk == 0) begin
            for (int k = 0; k < 4; k++) begin
                int t;
                t = (ecnt + (lat_short ? 2 : 3) + k) % 64;
                sv[t] = 1'b1; sa[t] = cmd_addr; sk[t] = k;
            end
            rblk = 3;
        end else if (rblk > 0) rblk--;
        mph = ~mph;
        ecnt++;
    endtask

    task automatic step();
        wr_data = (wrem > 0) ? gen(wseed, 4 - wrem) : 36'hA5A5A5A5A;
        wr_be_n = (wrem > 0) ? wmask : 4'b0000;
        @(posedge clk);
        @(negedge clk);
        model_edge();
    endtask

    task automatic cmd(input bit rd, input logic [AW-1:0] ra, input bit wr,
                       input logic [AW-1:0] wa, input logic [7:0] sd, input logic [3:0] mk);
        while (mph != 1'b0) step();
        rd_sel_n = ~rd; wr_sel_n = 1'b1; cmd_addr = ra;
        step();
        rd_sel_n = 1'b1; wr_sel_n = ~wr; cmd_addr = wa; nseed = sd; nmask = mk;
        step();
        wr_sel_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 1'b0;
        // R2: after reset the first beat is a read phase
        check(phase == 1'b0, "R2", "phase after reset", {36'd0, phase}, '0);
        for (int i = 0; i < NV; i++) begin
            cur_req = $sformatf("R%0d", int'(VEC[i][3:0]));
            cmd(VEC[i][25], VEC[i][24:21], VEC[i][20], VEC[i][19:16],
                VEC[i][15:8], VEC[i][7:4]);
        end
        cur_req = "R8";
        idle(10);
        // R2: selects in the wrong phase are ignored
        cur_req = "R2";
        while (mph != 1'b0) step();
        wr_sel_n = 1'b0; cmd_addr = 4'd15;
        step();
        wr_sel_n = 1'b1; rd_sel_n = 1'b0; cmd_addr = 4'd3;
        step();
        rd_sel_n = 1'b1;
        idle(6);
        cmd(1'b1, 4'd15, 1'b0, 4'd0, 8'h00, 4'b0000);
        idle(8);
        // R7: short latency, with and without forwarding
        cur_req = "R7";
        lat_short = 1'b1;
        cmd(1'b1, 4'd3, 1'b1, 4'd9, 8'hA1, 4'b0000);
        cmd(1'b1, 4'd9, 1'b0, 4'd0, 8'h00, 4'b0000);
        cmd(1'b0, 4'd0, 1'b1, 4'd9, 8'hB2, 4'b0110);
        cmd(1'b1, 4'd9, 1'b0, 4'd0, 8'h00, 4'b0000);
        idle(8);
        lat_short = 1'b0;
        // R11: reset in the middle of a write drops it
        cur_req = "R11";
        cmd(1'b0, 4'd0, 1'b1, 4'd5, 8'hC3, 4'b0000);
        idle(1);
        rst = 1'b1;
        step();
        rst = 1'b0;
        cmd(1'b1, 4'd5, 1'b0, 4'd0, 8'h00, 4'b0000);
        idle(8);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule